// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

This block is an 8-bit timer/counter with a waveform generator. A 3-bit mode selector picks one of six working modes: free-running counting, clear-on-compare, fast PWM (single slope) and phase-correct PWM (dual slope). In the two PWM families, the period end (TOP) is either the full count 0xFF or compare value A. Two compare channels, A and B, each drive one output pin. A 2-bit output-mode field controls each pin. The counter advances only on cycles where the prescaled count-enable input `tick` is high.

The compare values are double-buffered. In the non-PWM modes the value on the input port takes effect at once. In fast PWM a new value is taken when the counter wraps. In phase-correct PWM it is taken when the counter turns at TOP. The block raises a one-cycle overflow strobe and one-cycle compare strobes. The point in the count where overflow is reported depends on the mode. A compare value equal to TOP in a PWM mode gives a steady pin level with no glitch.

Top module: `pwm_timer8`

## Requirements
- R1: While `rst_n` is low, `count_o`, both pins and all three flags are 0.
- R2: Mode 0: each tick increments the count, with 0xFF wrapping to 0x00. `ovf_flag` pulses for one clock after a tick that found the count at 0xFF.
- R3: Mode 2 (TOP = compare A): a tick that finds the count equal to TOP loads 0. Otherwise the count increments. `ovf_flag` pulses after a tick at 0xFF.
- R4: Modes 3 (TOP = 0xFF) and 7 (TOP = compare A): a tick at TOP loads 0. Otherwise the count increments. `ovf_flag` follows a tick at 0xFF in mode 3, and a tick at TOP in mode 7.
- R5: Modes 1 (TOP = 0xFF) and 5 (TOP = compare A): the count rises to TOP and then falls to 0. TOP and 0 each last one tick. `ovf_flag` follows every tick that finds the count at 0.
- R6: The effective compare value follows its input at once in modes 0, 2, 4 and 6. In modes 3 and 7 it is reloaded on a tick at TOP. In modes 1 and 5 it is reloaded on the tick that turns the counter at TOP.
- R7: `match_a_flag` and `match_b_flag` pulse for one clock after a tick that finds the count equal to that channel's effective compare value. This applies in every non-reserved mode.
- R8: Modes 0 and 2, on a compare hit: output mode 01 toggles the pin, 10 drives it low and 11 drives it high.
- R9: Modes 3 and 7: output mode 10 drives the pin high on a tick at TOP and low on a hit. Output mode 11 does the opposite.
- R10: Modes 1 and 5: output mode 10 drives the pin low on a hit while the count is rising and high on a hit while it is falling. Output mode 11 does the opposite. A hit with the count at 0 counts as rising.
- R11: In PWM modes, when the effective compare value equals TOP, the hit is ignored. In fast PWM the pin is still set or cleared at the wrap. In phase-correct PWM it is set (10) or cleared (11) at TOP. The pin therefore holds a steady level.
- R12: Output mode 00 drives the pin low in every mode. In the PWM modes, output mode 01 also drives the pin low.
- R13: Modes 4 and 6 are reserved. The count and the pins hold and no flag pulses.
- R14: A cycle with `tick` low changes neither the count nor a pin driven by output mode 01, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Prescaled count enable |
| wg_mode | input | 3 | Waveform mode select (0..7) |
| cmp_a | input | 8 | Compare value A (also TOP in modes 2, 5, 7) |
| cmp_b | input | 8 | Compare value B |
| om_a | input | 2 | Output mode for pin A |
| om_b | input | 2 | Output mode for pin B |
| count_o | output | 8 | Current counter value |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| ovf_flag | output | 1 | One-cycle overflow strobe |
| match_a_flag | output | 1 | One-cycle compare A strobe |
| match_b_flag | output | 1 | One-cycle compare B strobe |

## Verification
The hardest case to reach is a compare value that changes while the counter is partway through a period in a buffered mode. There the old value must stay in force until the wrap or turn point. This matters most in modes 5 and 7, where the same change also moves TOP. The stimulus sweeps every mode against every output-mode pair and switches both compare inputs halfway through each run. It uses value sets that include 0, 0xFF, B equal to A and B above A. Some runs gate `tick` irregularly, so that the reload lands on varied cycles.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam logic [2:0] WG_NORMAL    = 3'd0;
  localparam logic [2:0] WG_PC_FULL   = 3'd1;
  localparam logic [2:0] WG_CTC       = 3'd2;
  localparam logic [2:0] WG_FAST_FULL = 3'd3;
  localparam logic [2:0] WG_RSV_LO    = 3'd4;
  localparam logic [2:0] WG_PC_A      = 3'd5;
  localparam logic [2:0] WG_RSV_HI    = 3'd6;
  localparam logic [2:0] WG_FAST_A    = 3'd7;

  localparam logic [1:0] OM_OFF    = 2'd0;
  localparam logic [1:0] OM_TOGGLE = 2'd1;
  localparam logic [1:0] OM_CLEAR  = 2'd2;
  localparam logic [1:0] OM_SET    = 2'd3;

  function automatic logic wg_is_pc(input logic [2:0] m);
    return (m == WG_PC_FULL) || (m == WG_PC_A);
  endfunction

  function automatic logic wg_is_fast(input logic [2:0] m);
    return (m == WG_FAST_FULL) || (m == WG_FAST_A);
  endfunction

  function automatic logic wg_is_rsv(input logic [2:0] m);
    return (m == WG_RSV_LO) || (m == WG_RSV_HI);
  endfunction

  // compare values act at once when no PWM family is selected
  function automatic logic wg_is_imm(input logic [2:0] m);
    return !(wg_is_pc(m) || wg_is_fast(m));
  endfunction

  function automatic logic wg_top_is_a(input logic [2:0] m);
    return (m == WG_CTC) || (m == WG_PC_A) || (m == WG_FAST_A);
  endfunction

endpackage

// File: rtl/pwm_cnt_unit.sv
module pwm_cnt_unit
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt_q,
  output logic         at_wrap,
  output logic         at_turn,
  output logic         up_dir,
  output logic         ovf_evt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ZERO = {W{1'b0}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic         dir_q, dir_d;
  logic [W-1:0] cnt_d;
  logic         pc, fast, rsv, run;

  always_comb begin
    pc      = wg_is_pc(mode);
    fast    = wg_is_fast(mode);
    rsv     = wg_is_rsv(mode);
    run     = tick && !rsv;
    at_wrap = (fast || (mode == WG_CTC)) && (cnt_q == top);
    at_turn = pc && !dir_q && (cnt_q >= top);
    up_dir  = (cnt_q == ZERO) || (!dir_q && (cnt_q < top));
    if (!run)                   ovf_evt = 1'b0;
    else if (mode == WG_FAST_A) ovf_evt = (cnt_q == top);
    else if (pc)                ovf_evt = (cnt_q == ZERO);
    else                        ovf_evt = (cnt_q == MAXV);
  end

  always_comb begin
    cnt_d = cnt_q;
    dir_d = pc ? dir_q : 1'b0;
    if (run) begin
      if (pc) begin
        if (!dir_q) begin
          if (cnt_q >= top) begin
            dir_d = 1'b1;
            cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else if (cnt_q == ZERO) begin
          dir_d = 1'b0;
          cnt_d = (top == ZERO) ? ZERO : ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end else if (mode == WG_NORMAL) begin
        cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = at_wrap ? ZERO : cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  p_hold_no_tick_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WG_CTC && cnt_q == top) |=> (cnt_q == ZERO));

  p_normal_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WG_NORMAL) |=> (cnt_q == W'($past(cnt_q) + ONE)));

  p_pc_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pc && !dir_q && cnt_q < top) |=> (cnt_q == W'($past(cnt_q) + ONE)));

endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         imm,
  input  logic         load,
  input  logic [W-1:0] cmp_in,
  output logic [W-1:0] cmp_eff
);

  logic [W-1:0] buf_q, buf_d;

  always_comb begin
    buf_d   = (imm || load) ? cmp_in : buf_q;
    cmp_eff = imm ? cmp_in : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm && !load) |=> $stable(buf_q));

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [1:0]   om,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] top,
  input  logic         at_wrap,
  input  logic         at_turn,
  input  logic         up_dir,
  output logic         wave_q
);

  logic wave_d, hit, pc, fast, rsv;

  always_comb begin
    pc     = wg_is_pc(mode);
    fast   = wg_is_fast(mode);
    rsv    = wg_is_rsv(mode);
    hit    = (cnt == cmp);
    wave_d = wave_q;
    if (om == OM_OFF) begin
      wave_d = 1'b0;
    end else if (rsv || !tick) begin
      wave_d = wave_q;
    end else if (pc || fast) begin
      if (om == OM_TOGGLE) begin
        wave_d = 1'b0;
      end else if (fast) begin
        // wrap action wins over a hit in the same tick (compare == TOP)
        if (at_wrap)  wave_d = (om == OM_CLEAR);
        else if (hit) wave_d = (om == OM_SET);
      end else begin
        if (at_turn && cmp == top) wave_d = (om == OM_CLEAR);
        else if (hit)              wave_d = up_dir ? (om == OM_SET) : (om == OM_CLEAR);
      end
    end else if (hit) begin
      wave_d = (om == OM_TOGGLE) ? !wave_q : (om == OM_SET);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  p_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (om == OM_OFF) |=> !wave_q);

  p_rsv_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv && om != OM_OFF) |=> $stable(wave_q));

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   wg_mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   om_a,
  input  logic [1:0]   om_b,
  output logic [W-1:0] count_o,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         match_a_flag,
  output logic         match_b_flag
);

  localparam int NCH = 2;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [1:0]   rst_sync_q;
  logic         rst_core_n;
  logic [W-1:0] cmp_in  [NCH];
  logic [W-1:0] cmp_eff [NCH];
  logic [1:0]   om      [NCH];
  logic [NCH-1:0] wave;
  logic [NCH-1:0] match_d, match_q;
  logic [W-1:0] cnt, top_val;
  logic         at_wrap, at_turn, up_dir, ovf_evt, ovf_q;
  logic         imm, load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    cmp_in[0] = cmp_a;
    cmp_in[1] = cmp_b;
    om[0]     = om_a;
    om[1]     = om_b;
    imm       = wg_is_imm(wg_mode);
    top_val   = wg_top_is_a(wg_mode) ? cmp_eff[0] : MAXV;
    load_evt  = tick && ((wg_is_fast(wg_mode) && at_wrap) || at_turn);
  end

  pwm_cnt_unit #(.W(W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick),
    .mode    (wg_mode),
    .top     (top_val),
    .cnt_q   (cnt),
    .at_wrap (at_wrap),
    .at_turn (at_turn),
    .up_dir  (up_dir),
    .ovf_evt (ovf_evt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_cmp_buf #(.W(W)) i_buf (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .imm     (imm),
      .load    (load_evt),
      .cmp_in  (cmp_in[ch]),
      .cmp_eff (cmp_eff[ch])
    );

    pwm_wave_out #(.W(W)) i_wave (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .tick    (tick),
      .mode    (wg_mode),
      .om      (om[ch]),
      .cnt     (cnt),
      .cmp     (cmp_eff[ch]),
      .top     (top_val),
      .at_wrap (at_wrap),
      .at_turn (at_turn),
      .up_dir  (up_dir),
      .wave_q  (wave[ch])
    );

    assign match_d[ch] = tick && !wg_is_rsv(wg_mode) && (cnt == cmp_eff[ch]);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ovf_q   <= 1'b0;
      match_q <= '0;
    end else begin
      ovf_q   <= ovf_evt;
      match_q <= match_d;
    end
  end

  assign count_o      = cnt;
  assign wave_a       = wave[0];
  assign wave_b       = wave[1];
  assign ovf_flag     = ovf_q;
  assign match_a_flag = match_q[0];
  assign match_b_flag = match_q[1];

  p_ovf_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    ovf_q |-> $past(tick));

  p_match_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|match_q) |-> $past(tick));

  p_rsv_no_flag_r13: assert property (@(posedge clk) disable iff (!rst_core_n)
    wg_is_rsv(wg_mode) |=> !ovf_q && (match_q == '0));

endmodule

// File: tb/test_pwm_timer8.sv
module test_pwm_timer8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] wg_mode = 3'd0;
  logic [7:0] cmp_a = 8'd0, cmp_b = 8'd0;
  logic [1:0] om_a = 2'd0, om_b = 2'd0;
  logic [7:0] count_o;
  logic       wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  int m_cnt, m_dir, m_bufa, m_bufb, m_wa, m_wb, m_ovf, m_ma, m_mb;
  int last_tick;
  bit second_half;

  always #5 clk = ~clk;

  pwm_timer8 #(.W(8)) i_pwm_timer8 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wg_mode(wg_mode),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .om_a(om_a), .om_b(om_b),
    .count_o(count_o), .wave_a(wave_a), .wave_b(wave_b),
    .ovf_flag(ovf_flag), .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s mode=%0d om=%0d/%0d a=%0d b=%0d: actual %0d expected %0d",
               tag, what, wg_mode, om_a, om_b, cmp_a, cmp_b, act, exp);
    end
  endtask

  function automatic int is_pc(int md);   return (md == 1 || md == 5) ? 1 : 0; endfunction
  function automatic int is_fast(int md); return (md == 3 || md == 7) ? 1 : 0; endfunction
  function automatic int is_rsv(int md);  return (md == 4 || md == 6) ? 1 : 0; endfunction

  function automatic int wnext(int w, int om, int md, int tk, int cnt, int eff,
                               int top, int wrap, int turn, int up);
    if (om == 0) return 0;
    if (is_rsv(md) == 1 || tk == 0) return w;
    if (is_pc(md) == 1 || is_fast(md) == 1) begin
      if (om == 1) return 0;
      if (is_fast(md) == 1) begin
        if (wrap == 1) return (om == 2) ? 1 : 0;
        if (cnt == eff) return (om == 3) ? 1 : 0;
        return w;
      end
      if (turn == 1 && eff == top) return (om == 2) ? 1 : 0;
      if (cnt == eff) return (up == 1) ? ((om == 3) ? 1 : 0) : ((om == 2) ? 1 : 0);
      return w;
    end
    if (cnt == eff) return (om == 1) ? 1 - w : ((om == 3) ? 1 : 0);
    return w;
  endfunction

  // reference model: advance by one clock using the inputs now applied
  task automatic step();
    int md, pc, fast, imm, ea, eb, top, wrap, turn, up, tk, load;
    int n_cnt, n_dir;
    md   = int'(wg_mode);
    pc   = is_pc(md);
    fast = is_fast(md);
    imm  = (pc == 0 && fast == 0) ? 1 : 0;
    ea   = (imm == 1) ? int'(cmp_a) : m_bufa;
    eb   = (imm == 1) ? int'(cmp_b) : m_bufb;
    top  = (md == 2 || md == 5 || md == 7) ? ea : 255;
    wrap = (m_cnt == top) ? 1 : 0;
    turn = (pc == 1 && m_dir == 0 && m_cnt >= top) ? 1 : 0;
    up   = (m_cnt == 0 || (m_dir == 0 && m_cnt < top)) ? 1 : 0;
    tk   = (tick && is_rsv(md) == 0) ? 1 : 0;
    m_wa = wnext(m_wa, int'(om_a), md, tk, m_cnt, ea, top, wrap, turn, up);
    m_wb = wnext(m_wb, int'(om_b), md, tk, m_cnt, eb, top, wrap, turn, up);
    if (tk == 0) m_ovf = 0;
    else if (md == 7) m_ovf = wrap;
    else if (pc == 1) m_ovf = (m_cnt == 0) ? 1 : 0;
    else m_ovf = (m_cnt == 255) ? 1 : 0;
    m_ma = (tk == 1 && m_cnt == ea) ? 1 : 0;
    m_mb = (tk == 1 && m_cnt == eb) ? 1 : 0;
    n_cnt = m_cnt;
    n_dir = (pc == 1) ? m_dir : 0;
    if (tk == 1) begin
      if (pc == 1) begin
        if (m_dir == 0) begin
          if (m_cnt >= top) begin n_dir = 1; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else n_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          n_dir = 0; n_cnt = (top == 0) ? 0 : 1;
        end else n_cnt = m_cnt - 1;
      end else if (md == 0) n_cnt = (m_cnt + 1) % 256;
      else n_cnt = (wrap == 1) ? 0 : (m_cnt + 1) % 256;
    end
    load = (tk == 1 && ((fast == 1 && wrap == 1) || turn == 1)) ? 1 : 0;
    if (imm == 1 || load == 1) begin m_bufa = int'(cmp_a); m_bufb = int'(cmp_b); end
    m_cnt = n_cnt;
    m_dir = n_dir;
    last_tick = tk;
  endtask

  function automatic string mode_tag(int md);
    case (md)
      0: return "R2";
      2: return "R3";
      3, 7: return "R4";
      1, 5: return "R5";
      default: return "R13";
    endcase
  endfunction

  function automatic string wave_tag(int md, int om, int cval);
    string t;
    int top;
    top = (md == 2 || md == 5 || md == 7) ? int'(cmp_a) : 255;
    if (om == 0 || ((is_pc(md) == 1 || is_fast(md) == 1) && om == 1)) t = "R12";
    else if (is_rsv(md) == 1) t = "R13";
    else if ((is_pc(md) == 1 || is_fast(md) == 1) && cval == top) t = "R11";
    else if (is_pc(md) == 1) t = "R10";
    else if (is_fast(md) == 1) t = "R9";
    else t = "R8";
    if (second_half) t = {t, " R6"};
    return t;
  endfunction

  task automatic compare_all();
    int md;
    md = int'(wg_mode);
    chk((last_tick == 0) ? "R14" : mode_tag(md), "count", int'(count_o), m_cnt);
    chk(mode_tag(md), "ovf_flag", int'(ovf_flag), m_ovf);
    chk("R7", "match_a_flag", int'(match_a_flag), m_ma);
    chk("R7", "match_b_flag", int'(match_b_flag), m_mb);
    chk(wave_tag(md, int'(om_a), int'(cmp_a)), "wave_a", int'(wave_a), m_wa);
    chk(wave_tag(md, int'(om_b), int'(cmp_b)), "wave_b", int'(wave_b), m_wb);
  endtask

  task automatic run_cfg(int md, int oma, int omb, int a1, int b1, int a2, int b2, int gated);
    int n;
    n = (is_rsv(md) == 1) ? 60 : 1100;
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0;
    wg_mode = 3'(md); om_a = 2'(oma); om_b = 2'(omb);
    cmp_a = 8'(a1); cmp_b = 8'(b1);
    second_half = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "wave_a", int'(wave_a), 0);
    chk("R1", "wave_b", int'(wave_b), 0);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);
    chk("R1", "match_a_flag", int'(match_a_flag), 0);
    chk("R1", "match_b_flag", int'(match_b_flag), 0);
    m_cnt = 0; m_dir = 0; m_bufa = 0; m_bufb = 0;
    m_wa = 0; m_wb = 0; m_ovf = 0; m_ma = 0; m_mb = 0; last_tick = 1;
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      compare_all();
      if (i == 500) begin
        cmp_a = 8'(a2); cmp_b = 8'(b2); second_half = 1;
      end
      tick = (gated == 1) ? ((i % 5) != 4) : 1'b1;
      step();
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    int sa1[3] = '{255, 64, 128};
    int sb1[3] = '{0, 64, 16};
    int sa2[3] = '{128, 32, 200};
    int sb2[3] = '{64, 255, 128};
    for (int md = 0; md < 8; md++)
      for (int om = 0; om < 4; om++)
        for (int s = 0; s < 3; s++)
          run_cfg(md, om, (om + 1) % 4, sa1[s], sb1[s], sa2[s], sb2[s], (om + s) % 2);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      report();
      $finish;
    end
  end

endmodule